// File: doc/BRIEF.md
# Status Pin Fault Pulse Indicator

This block drives an open-drain status pin for a battery charger that can also run its converter backwards as a boost supply. While charging is in progress and the status function is enabled, the pin is held low as a steady indication. When a new fault appears, the pin is pulled low for a single fixed-width pulse and then released. Outside those two cases the pin stays high impedance. Boost operation on its own never pulls the pin low.

Each fault source arrives as a flag. Separate flag sets are used for charge mode and boost mode, and the meaning of a code depends on the mode. A priority encoder turns the active set into a 3-bit code. Each new code is latched for readback by the register interface, which clears it with a one-cycle strobe. The width of the pulse is a count of clock cycles, derived from the clock frequency and the target width in microseconds. The default target is 128 us.

The pin output is a drive-low enable: 1 pulls the pad low and 0 releases it. Every input is sampled on the rising clock edge. Both outputs are registered and change one edge after the input that causes the change.

Top module: `stat_beacon`

## Requirements
- R1: While reset is asserted and after it is released, `pin_pull` is 0 and `fault_code` is 0 until an input changes them.
- R2: In charge mode (`boost_mode`=0), with `charging`=1 and `stat_en`=1 sampled at an edge, `pin_pull` is 1 after that edge.
- R3: With `stat_en`=0, `charging` never holds the pin low. Only fault pulses pull it.
- R4: In boost mode (`boost_mode`=1), `charging` is ignored. With no boost fault flag set, the pin is released once any pulse has ended.
- R5: A fault event pulls `pin_pull` high for exactly PULSE_CYCLES = CLK_KHZ*PULSE_US/1000 cycles, starting at the edge that samples the event. An event is a nonzero active code that differs from the code sampled at the previous edge.
- R6: A fault that persists with an unchanged code does not pulse again. A fault that goes away does not pulse.
- R7: A change to a different nonzero code restarts the pulse for a full PULSE_CYCLES, even if a pulse is already running.
- R8: In charge mode, flag bit i of `chg_flags` (bit 0 input OVP, 1 sleep, 2 bad adaptor/UVLO, 3 output OVP, 4 thermal, 5 timer, 6 no battery) gives code i+1. The lowest set bit wins.
- R9: In boost mode, flag bit i of `bst_flags` (bit 0 VBUS OVP, 1 overload, 2 battery low, 3 battery OVP, 4 thermal, 5 timer) gives code i+1. The lowest set bit wins. Code 7 never arises in boost mode. The flag set of the inactive mode is ignored.
- R10: `fault_code` holds the code of the last event until `clr_code` is sampled high, which sets it to 0.
- R11: When an event and `clr_code` are sampled at the same edge, the new code is latched and the clear is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boost_mode | input | 1 | 1 selects boost mode, 0 selects charge mode |
| charging | input | 1 | Charge in progress |
| stat_en | input | 1 | Enables the steady charging indication |
| chg_flags | input | 7 | Charge-mode fault flags |
| bst_flags | input | 6 | Boost-mode fault flags |
| clr_code | input | 1 | Register-interface strobe that clears the latched code |
| pin_pull | output | 1 | 1 pulls the status pin low, 0 releases it |
| fault_code | output | 3 | Latched fault code |

## Verification
Two collisions can happen in one cycle.

The first is a register-interface clear arriving at the same edge as a fresh fault. The bench drives `clr_code` together with a newly set boost flag. It then expects the new code to survive (R11) and a full pulse to follow.

The second is a fault pulse overlapping the steady charging indication. The bench covers this by letting random segments set `charging`, `stat_en` and fault flags together. A cycle-by-cycle bench model ORs the two causes, and any cycle where the pin drops early is reported.

// File: rtl/stat_beacon_pkg.sv
package stat_beacon_pkg;
  localparam int CODE_W  = 3;
  localparam int N_CHG   = 7;
  localparam int N_BST   = 6;
  typedef logic [CODE_W-1:0] fcode_t;
  localparam fcode_t CODE_NONE = '0;
endpackage

// File: rtl/lowest_flag_enc.sv
module lowest_flag_enc
  import stat_beacon_pkg::*;
#(
  parameter int N = 7
) (
  input  logic [N-1:0] flags,
  output fcode_t       code
);
  always_comb begin
    code = CODE_NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (flags[i]) code = fcode_t'(i + 1);
    end
  end
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(LEN - 1);

  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left <= '0;
      busy <= 1'b0;
    end else if (start) begin
      left <= LOAD;
      busy <= 1'b1;
    end else if (busy) begin
      if (left == '0) busy <= 1'b0;
      else            left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/stat_beacon.sv
module stat_beacon
  import stat_beacon_pkg::*;
#(
  parameter int CLK_KHZ  = 200_000,
  parameter int PULSE_US = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boost_mode,
  input  logic             charging,
  input  logic             stat_en,
  input  logic [N_CHG-1:0] chg_flags,
  input  logic [N_BST-1:0] bst_flags,
  input  logic             clr_code,
  output logic             pin_pull,
  output logic [CODE_W-1:0] fault_code
);
  localparam int RAW_CYCLES   = (CLK_KHZ * PULSE_US) / 1000;
  localparam int PULSE_CYCLES = (RAW_CYCLES < 1) ? 1 : RAW_CYCLES;

  fcode_t chg_code, bst_code, act_code, prev_code, code_q;
  logic   fault_event, pulse_busy, steady_q;

  lowest_flag_enc #(.N(N_CHG)) u_chg_enc (.flags(chg_flags), .code(chg_code));
  lowest_flag_enc #(.N(N_BST)) u_bst_enc (.flags(bst_flags), .code(bst_code));

  assign act_code    = boost_mode ? bst_code : chg_code;
  assign fault_event = (act_code != CODE_NONE) && (act_code != prev_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_code <= CODE_NONE;
      code_q    <= CODE_NONE;
      steady_q  <= 1'b0;
    end else begin
      prev_code <= act_code;
      steady_q  <= !boost_mode && charging && stat_en;
      if (fault_event)   code_q <= act_code;
      else if (clr_code) code_q <= CODE_NONE;
    end
  end

  oneshot_timer #(.LEN(PULSE_CYCLES)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start(fault_event), .busy(pulse_busy)
  );

  assign pin_pull   = pulse_busy | steady_q;
  assign fault_code = code_q;
endmodule

// File: rtl/stat_beacon_chk.sv
module stat_beacon_chk #(
  parameter int PULSE_CYCLES = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       boost_mode,
  input logic       charging,
  input logic       stat_en,
  input logic [6:0] chg_flags,
  input logic [5:0] bst_flags,
  input logic       clr_code,
  input logic       pin_pull,
  input logic [2:0] fault_code
);
  localparam int QW = $clog2(PULSE_CYCLES + 3);

  logic          active, prev_active;
  logic [QW-1:0] quiet;

  assign active = boost_mode ? (bst_flags != '0) : (chg_flags != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_active <= 1'b0;
      quiet       <= '0;
    end else begin
      prev_active <= active;
      if (active) quiet <= '0;
      else if (int'(quiet) <= PULSE_CYCLES) quiet <= quiet + 1'b1;
    end
  end

  p_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!boost_mode && charging && stat_en) |=> pin_pull);

  p_boost_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (boost_mode && !active && int'(quiet) > PULSE_CYCLES) |=> !pin_pull);

  p_fault_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !prev_active) |=> pin_pull);

  p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_code && !active) |=> (fault_code == 3'd0));

  p_hold_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_code && !active) |=> $stable(fault_code));

  p_no_seven_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (boost_mode && active) |=> (fault_code != 3'd7));
endmodule

bind stat_beacon stat_beacon_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_stat_beacon_chk (
  .clk(clk), .rst_n(rst_n), .boost_mode(boost_mode), .charging(charging),
  .stat_en(stat_en), .chg_flags(chg_flags), .bst_flags(bst_flags),
  .clr_code(clr_code), .pin_pull(pin_pull), .fault_code(fault_code)
);

// File: tb/test_stat_beacon.sv
module test_stat_beacon;
  localparam int CLK_KHZ  = 1000;
  localparam int PULSE_US = 16;
  localparam int P        = (CLK_KHZ * PULSE_US) / 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       boost_mode = 1'b0, charging = 1'b0, stat_en = 1'b0, clr_code = 1'b0;
  logic [6:0] chg_flags = '0;
  logic [5:0] bst_flags = '0;
  logic       pin_pull;
  logic [2:0] fault_code;

  int vectors = 0;
  int fails   = 0;

  logic [2:0] exp_prev, exp_code;
  int         exp_left;
  logic       exp_steady, exp_pin;

  always #2.5 clk = ~clk;

  stat_beacon #(.CLK_KHZ(CLK_KHZ), .PULSE_US(PULSE_US)) i_stat_beacon (
    .clk(clk), .rst_n(rst_n), .boost_mode(boost_mode), .charging(charging),
    .stat_en(stat_en), .chg_flags(chg_flags), .bst_flags(bst_flags),
    .clr_code(clr_code), .pin_pull(pin_pull), .fault_code(fault_code)
  );

  function automatic logic [2:0] low_code(input logic [6:0] f, input int n);
    for (int i = 0; i < n; i++) if (f[i]) return 3'(i + 1);
    return 3'd0;
  endfunction

  function automatic logic [2:0] mode_code(input logic b, input logic [6:0] c,
                                           input logic [5:0] s);
    return b ? low_code({1'b0, s}, 6) : low_code(c, 7);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_prev = 0; exp_code = 0; exp_left = 0; exp_steady = 0;
    end else begin
      logic [2:0] r;
      r = mode_code(boost_mode, chg_flags, bst_flags);
      if (r != 0 && r != exp_prev) begin
        exp_left = P; exp_code = r;
      end else begin
        if (exp_left > 0) exp_left--;
        if (clr_code) exp_code = 0;
      end
      exp_prev   = r;
      exp_steady = !boost_mode && charging && stat_en;
    end
    exp_pin = (exp_left > 0) || exp_steady;
  end

  task automatic chk(input string tag);
    vectors++;
    if (pin_pull !== exp_pin || fault_code !== exp_code) begin
      fails++;
      $display("FAIL %s pin=%0b exp %0b code=%0d exp %0d at %0t",
               tag, pin_pull, exp_pin, fault_code, exp_code, $time);
    end
  endtask

  task automatic run(input int n, input string tag);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
      chk(tag);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run still busy, expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1");
    rst_n = 1'b1;
    run(3, "R1");
    charging = 1; stat_en = 1;
    run(5, "R2");
    stat_en = 0;
    run(5, "R3");
    stat_en = 1; boost_mode = 1;
    run(5, "R4");
    boost_mode = 0; charging = 0;
    chg_flags = 7'b0010100;
    run(P + 5, "R5");
    run(6, "R6");
    chg_flags = '0;
    run(5, "R6");
    clr_code = 1;
    run(1, "R10");
    clr_code = 0;
    run(3, "R10");
    chg_flags = 7'b1000000;
    run(4, "R8");
    chg_flags = 7'b1000001;
    run(P + 4, "R7");
    boost_mode = 1;
    run(P + 3, "R9");
    bst_flags = 6'b111111;
    run(3, "R9");
    bst_flags = 6'b100000;
    run(P + 3, "R9");
    bst_flags = '0; chg_flags = '0;
    run(2, "R11");
    bst_flags = 6'b000100; clr_code = 1;
    run(1, "R11");
    clr_code = 0;
    run(P + 2, "R11");
    for (int seg = 0; seg < 200; seg++) begin
      boost_mode = 1'($urandom_range(0, 1));
      charging   = 1'($urandom_range(0, 1));
      stat_en    = 1'($urandom_range(0, 1));
      chg_flags  = ($urandom_range(0, 3) == 0) ? 7'($urandom) : 7'd0;
      bst_flags  = ($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'd0;
      clr_code   = ($urandom_range(0, 7) == 0);
      run(1, "R5");
      clr_code = 0;
      run($urandom_range(1, 40), "R8");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule